// File: doc/BRIEF.md
# Local Bus Release Arbiter

This block decides when a processor hands its local bus to another bus master and when it takes the bus back. It has two request schemes, and a mode input selects which one applies. In minimum mode a single hold request line, usually driven by a DMA engine, asks for the bus. The arbiter answers on a hold-acknowledge output. In maximum mode two external masters each have a request line, and the arbiter answers on one grant output per master. Requester 0 takes precedence over requester 1.

Every request input is asynchronous and passes through a synchronizer before the arbiter looks at it. The bus is handed over only when two conditions hold at the same time: the bus unit reports no bus cycle in flight, and no locked instruction is running. In the cycle that the acknowledge or grant rises, the arbiter also raises a float enable. That enable tristates the processor's address, data and control drivers. When the master that owns the bus drops its request, the acknowledge or grant falls. The float enable falls one clock later, and the processor then resumes its own bus cycles.

Top module: `bus_release_arbiter`

## Requirements
- R1: While reset is applied, hold_ack, every rq_grant bit and bus_float are all 0.
- R2: Minimum mode is selected when min_mode is 1. A hold_req held at 1 with the bus idle and unlocked makes hold_ack and bus_float rise together after the third rising clock edge that samples it.
- R3: No acknowledge or grant starts on an edge where cycle_busy is 1. Once cycle_busy falls with a request still pending, the hand-off happens on the next edge.
- R4: No acknowledge or grant starts on an edge where lock_active is 1. Once lock_active falls with a request still pending, the hand-off happens on the next edge.
- R5: Maximum mode is selected when min_mode is 0. When both request lines are pending together, bit 0 of rq_grant is given and bit 1 is not.
- R6: A grant is never taken away by a new request. A request that waits behind an active grant is served on the second edge after that grant falls.
- R7: The owner's request is seen low after synchronization. On that edge the acknowledge or grant falls while bus_float stays 1, and on the next edge bus_float falls.
- R8: In minimum mode the rq_req lines cause no grant. In maximum mode hold_req causes no acknowledge.
- R9: At most one of hold_ack and the rq_grant bits is 1 at any time. Whenever any of them is 1, bus_float is 1.
- R10: A request that is withdrawn while the hand-off is blocked, before it has been granted, produces no acknowledge or grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| min_mode | input | 1 | 1 selects minimum mode, 0 selects maximum mode |
| hold_req | input | 1 | Asynchronous bus request used in minimum mode |
| rq_req | input | NREQ | Asynchronous request per external master in maximum mode, bit 0 highest priority |
| cycle_busy | input | 1 | A bus cycle is in progress |
| lock_active | input | 1 | A locked instruction is executing |
| hold_ack | output | 1 | Bus handed over in minimum mode |
| rq_grant | output | NREQ | Bus handed over to that requester in maximum mode |
| bus_float | output | 1 | Tristate enable for the processor's bus drivers |

## Verification
The bench uses the default parameters: two requesters and two synchronizer stages. With two stages the hand-off latency is a fixed three edges, so the reference model can predict every acknowledge and grant exactly, including the edge where a request is seen dropping. With two requesters, simultaneous requests, a low-priority request waiting behind a held grant, and the two-edge gap before the next owner are all reachable in a few dozen cycles. A long random phase then mixes mode, busy and lock against the same model.

// File: rtl/bra_pkg.sv
// Shared types for the bus release arbiter.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package bra_pkg;

    // Ownership state of the local bus.
    typedef enum logic [1:0] {
        ST_OWNED   = 2'd0,   // processor drives the bus
        ST_LENT    = 2'd1,   // another master holds the bus
        ST_RECLAIM = 2'd2    // grant withdrawn, drivers still floating
    } own_state_e;

endpackage

// File: rtl/bra_req_sync.sv
// Multi-stage synchronizer for a vector of asynchronous request lines.
// Assumes: STAGES >= 2; each bit is an independent level signal.
module bra_req_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/bra_prio_pick.sv
// Fixed-priority picker: the lowest-numbered active request wins.
// Assumes: N >= 1; purely combinational.
module bra_prio_pick #(
    parameter int N    = 2,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    // Scan from lowest priority to highest so the highest one found last wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/bra_own_fsm.sv
// Ownership state machine. Lends the bus only in an idle, unlocked cycle,
// then reclaims it one clock after the owner's grant is withdrawn.
// Assumes: request inputs are already synchronized; all outputs are registered.
module bra_own_fsm
    import bra_pkg::*;
#(
    parameter int N    = 2,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            min_mode,
    input  logic            hold_s,
    input  logic [N-1:0]    rq_s,
    input  logic            pick_found,
    input  logic [IDXW-1:0] pick_idx,
    input  logic            cycle_busy,
    input  logic            lock_active,
    output logic            hold_ack,
    output logic [N-1:0]    rq_grant,
    output logic            bus_float
);

    own_state_e      state_q, state_d;
    logic            own_hold_q, own_hold_d;
    logic [IDXW-1:0] own_idx_q, own_idx_d;
    logic            want_bus;
    logic            owner_still;
    logic            may_lend;

    // A master wants the bus under the request scheme of the current mode.
    assign want_bus    = min_mode ? hold_s : pick_found;
    // The current owner still holds its request.
    assign owner_still = own_hold_q ? hold_s : rq_s[own_idx_q];
    // The hand-off is allowed only between bus cycles and outside a lock.
    assign may_lend    = !cycle_busy && !lock_active;

    // Next ownership state and recorded owner.
    always_comb begin
        state_d    = state_q;
        own_hold_d = own_hold_q;
        own_idx_d  = own_idx_q;
        unique case (state_q)
            ST_OWNED: begin
                if (want_bus && may_lend) begin
                    state_d    = ST_LENT;
                    own_hold_d = min_mode;
                    own_idx_d  = pick_idx;
                end
            end
            ST_LENT: begin
                if (!owner_still) state_d = ST_RECLAIM;
            end
            ST_RECLAIM: state_d = ST_OWNED;
            default:    state_d = ST_OWNED;
        endcase
    end

    // State and owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OWNED;
            own_hold_q <= 1'b0;
            own_idx_q  <= '0;
        end else begin
            state_q    <= state_d;
            own_hold_q <= own_hold_d;
            own_idx_q  <= own_idx_d;
        end
    end

    assign hold_ack  = (state_q == ST_LENT) && own_hold_q;
    assign bus_float = (state_q != ST_OWNED);

    generate
        for (genvar g = 0; g < N; g++) begin : g_grant
            assign rq_grant[g] = (state_q == ST_LENT) && !own_hold_q &&
                                 (own_idx_q == IDXW'(g));
        end
    endgenerate

endmodule

// File: rtl/bus_release_arbiter.sv
// Top level of the local bus release arbiter: synchronizers, fixed
// priority picker and ownership state machine.
// Assumes: min_mode changes only while the bus is owned by the processor.
module bus_release_arbiter #(
    parameter int NREQ        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            min_mode,
    input  logic            hold_req,
    input  logic [NREQ-1:0] rq_req,
    input  logic            cycle_busy,
    input  logic            lock_active,
    output logic            hold_ack,
    output logic [NREQ-1:0] rq_grant,
    output logic            bus_float
);

    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int SW   = NREQ + 1;

    logic [SW-1:0]   raw_req;
    logic [SW-1:0]   syn_req;
    logic            pick_found;
    logic [IDXW-1:0] pick_idx;

    assign raw_req = {rq_req, hold_req};

    bra_req_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_req),
        .sync_out (syn_req)
    );

    bra_prio_pick #(.N(NREQ), .IDXW(IDXW)) i_pick (
        .req   (syn_req[SW-1:1]),
        .found (pick_found),
        .idx   (pick_idx)
    );

    bra_own_fsm #(.N(NREQ), .IDXW(IDXW)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .min_mode    (min_mode),
        .hold_s      (syn_req[0]),
        .rq_s        (syn_req[SW-1:1]),
        .pick_found  (pick_found),
        .pick_idx    (pick_idx),
        .cycle_busy  (cycle_busy),
        .lock_active (lock_active),
        .hold_ack    (hold_ack),
        .rq_grant    (rq_grant),
        .bus_float   (bus_float)
    );

endmodule

// File: rtl/bra_checks.sv
// Property checker for the bus release arbiter, bound to the top module.
// Assumes: observes ports only.
module bra_checks #(
    parameter int NREQ = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            min_mode,
    input logic            cycle_busy,
    input logic            lock_active,
    input logic            hold_ack,
    input logic [NREQ-1:0] rq_grant,
    input logic            bus_float
);

    logic any_give;
    assign any_give = hold_ack || (|rq_grant);

    // R9: a single owner at a time
    a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold_ack, rq_grant}));

    // R9: drivers float whenever the bus is given away
    a_r9_float_covers: assert property (@(posedge clk) disable iff (!rst_n)
        any_give |-> bus_float);

    // R3: hand-off only after an idle edge
    a_r3_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> $past(!cycle_busy));

    // R4: hand-off never during a lock
    a_r4_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> $past(!lock_active));

    // R7: float outlasts the grant by exactly one clock
    a_r7_float_trail: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_give) |-> (bus_float ##1 !bus_float));

    // R2: acknowledge rises only when minimum mode was selected
    a_r2_ack_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(min_mode));

endmodule

bind bus_release_arbiter bra_checks #(.NREQ(NREQ)) i_bra_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .min_mode    (min_mode),
    .cycle_busy  (cycle_busy),
    .lock_active (lock_active),
    .hold_ack    (hold_ack),
    .rq_grant    (rq_grant),
    .bus_float   (bus_float)
);

// File: tb/test_bus_release_arbiter.sv
// Bench for the bus release arbiter: behavioural reference model compared
// every clock, plus directed checks of each requirement.
module test_bus_release_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_mode = 1'b1;
    logic       hold_req = 1'b0;
    logic [1:0] rq_req = 2'b00;
    logic       cycle_busy = 1'b0;
    logic       lock_active = 1'b0;
    logic       hold_ack;
    logic [1:0] rq_grant;
    logic       bus_float;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  cmp_on  = 0;
    bit  done    = 0;

    always #4 clk = ~clk;   // 125 MHz

    bus_release_arbiter i_bus_release_arbiter (
        .clk(clk), .rst_n(rst_n), .min_mode(min_mode), .hold_req(hold_req),
        .rq_req(rq_req), .cycle_busy(cycle_busy), .lock_active(lock_active),
        .hold_ack(hold_ack), .rq_grant(rq_grant), .bus_float(bus_float)
    );

    // ---------------- reference model ----------------
    bit       m_h1, m_h2;
    bit [1:0] m_r1, m_r2;
    int       m_state;     // 0 processor, 1 lent, 2 reclaim
    bit       m_own_hold;
    int       m_own_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h1 = 0; m_h2 = 0; m_r1 = 0; m_r2 = 0;
            m_state = 0; m_own_hold = 0; m_own_idx = 0;
        end else begin
            case (m_state)
                0: begin
                    bit want;
                    want = min_mode ? m_h2 : (m_r2 != 0);
                    if (want && !cycle_busy && !lock_active) begin
                        m_state    = 1;
                        m_own_hold = min_mode;
                        m_own_idx  = m_r2[0] ? 0 : 1;
                    end
                end
                1: begin
                    bit still;
                    still = m_own_hold ? m_h2 : m_r2[m_own_idx];
                    if (!still) m_state = 2;
                end
                default: m_state = 0;
            endcase
            m_h2 = m_h1; m_h1 = hold_req;
            m_r2 = m_r1; m_r1 = rq_req;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit       e_ack;
            bit [1:0] e_gnt;
            bit       e_flt;
            e_ack = (m_state == 1) && m_own_hold;
            e_gnt = ((m_state == 1) && !m_own_hold) ? (2'b01 << m_own_idx) : 2'b00;
            e_flt = (m_state != 0);
            n_tests++;
            if (hold_ack !== e_ack || rq_grant !== e_gnt || bus_float !== e_flt) begin
                n_fail++;
                $display("FAIL model R2/R5/R7/R9 t=%0t ack=%b gnt=%b flt=%b expected ack=%b gnt=%b flt=%b",
                         $time, hold_ack, rq_grant, bus_float, e_ack, e_gnt, e_flt);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual {ack,gnt,flt}=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {hold_ack, rq_grant, bus_float};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        cmp_on = 1;
        step(3);
        chk("R1 reset state", outs(), 4'b0000);
        rst_n = 1'b1;
        step(2);

        // R2: minimum mode hand-off after three edges
        min_mode = 1'b1;
        hold_req = 1'b1;
        step(2);
        chk("R2 not yet", outs(), 4'b0000);
        step(1);
        chk("R2 ack and float", outs(), 4'b1001);
        step(3);
        hold_req = 1'b0;
        step(3);
        chk("R7 ack falls, float held", outs(), 4'b0001);
        step(1);
        chk("R7 float released", outs(), 4'b0000);
        step(2);

        // R3: blocked while a bus cycle runs
        cycle_busy = 1'b1;
        hold_req   = 1'b1;
        step(6);
        chk("R3 busy blocks", outs(), 4'b0000);
        cycle_busy = 1'b0;
        step(1);
        chk("R3 granted when idle", outs(), 4'b1001);
        hold_req = 1'b0;
        step(5);

        // R4: blocked during a lock
        lock_active = 1'b1;
        hold_req    = 1'b1;
        step(6);
        chk("R4 lock blocks", outs(), 4'b0000);
        lock_active = 1'b0;
        step(1);
        chk("R4 granted after lock", outs(), 4'b1001);
        hold_req = 1'b0;
        step(5);

        // R8: each mode ignores the other scheme
        rq_req = 2'b11;
        step(6);
        chk("R8 rq ignored in min mode", outs(), 4'b0000);
        rq_req = 2'b00;
        step(3);
        min_mode = 1'b0;
        hold_req = 1'b1;
        step(6);
        chk("R8 hold ignored in max mode", outs(), 4'b0000);
        hold_req = 1'b0;
        step(3);

        // R5: both pending, requester 0 wins
        rq_req = 2'b11;
        step(3);
        chk("R5 priority to bit 0", outs(), 4'b0011);
        rq_req = 2'b10;
        step(3);
        chk("R7 grant falls, float held", outs(), 4'b0001);
        step(1);
        chk("R6 bus returned between owners", outs(), 4'b0000);
        step(1);
        chk("R6 waiting requester served", outs(), 4'b0101);
        rq_req = 2'b00;
        step(5);

        // R6: no preemption by a higher-priority latecomer
        rq_req = 2'b10;
        step(3);
        chk("R6 low requester granted", outs(), 4'b0101);
        rq_req = 2'b11;
        step(6);
        chk("R6 not preempted", outs(), 4'b0101);
        rq_req = 2'b01;
        step(3);
        chk("R6 released", outs(), 4'b0001);
        step(2);
        chk("R6 waiting high requester served", outs(), 4'b0011);
        rq_req = 2'b00;
        step(5);

        // R10: request withdrawn while blocked
        min_mode   = 1'b1;
        cycle_busy = 1'b1;
        hold_req   = 1'b1;
        step(1);
        hold_req   = 1'b0;
        step(4);
        cycle_busy = 1'b0;
        step(4);
        chk("R10 withdrawn request not granted", outs(), 4'b0000);

        // Random phase against the model (R9 and all timing)
        for (int i = 0; i < 3000; i++) begin
            bit [7:0] r;
            r = 8'($urandom);
            if (!bus_float && r[7:6] == 2'b00) min_mode = r[0];
            if (r[5:4] == 2'b00) hold_req = ~hold_req;
            if (r[3:2] == 2'b00) rq_req = 2'($urandom);
            cycle_busy  = (r[1:0] != 2'b11) ? r[1] : cycle_busy;
            lock_active = (r[7:5] == 3'b111);
            step(1);
            n_tests++;
            if ((int'(hold_ack) + $countones(rq_grant)) > 1 ||
                ((hold_ack || rq_grant != 0) && !bus_float)) begin
                n_fail++;
                $display("FAIL R9 ack=%b gnt=%b flt=%b expected one owner with float",
                         hold_ack, rq_grant, bus_float);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule